// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Pin Cells

This block is a test access port driven by the four standard serial pins (TCK, TMS, TDI, TDO) plus an active-low asynchronous reset. It sits between the core logic and the pads. Each pin has a small group of boundary cells, and together those cells form one serial scan chain. Elaboration parameters fix the pin count and the kind of each pin. A pin can be input-only, output-only, tristate output or bidirectional. Each kind adds a fixed number of cells to the chain, so the chain length and the cell layout follow from the pin mix.

The instruction register is 3 bits wide. The instructions are:
- an identification register;
- a one-bit bypass register;
- a sample/preload instruction that leaves the pins in functional pass-through;
- an external-test instruction that drives the pads and the core inputs from the update latches;
- one user data register whose parallel output and parallel input are brought out to the core.

Under user control through TMS, the block walks the usual sixteen-state controller. Capture and shift happen on the rising edge of TCK. The update latches and TDO change on the falling edge of TCK.

Top module: `jtag_bscan_tap`

## Requirements
- R1: The controller follows TMS through the sixteen standard states on rising TCK. Five consecutive TMS-high cycles reach Test-Logic-Reset from any state.
- R2: Every instruction load shifts exactly 3 bits, least significant bit first. The bits shifted out are the capture pattern 3'b001. The new instruction takes effect on the falling edge of TCK in Update-IR.
- R3: After reset, and whenever the controller is in Test-Logic-Reset, the instruction is IDCODE (code 3'b001). A data scan then returns the 32-bit identifier, LSB first, and that LSB is 1.
- R4: BYPASS (code 3'b111, and also the unassigned codes 3'b100, 3'b101 and 3'b110) selects a one-bit register that captures 0. Scanned data therefore comes out delayed by one TCK: bit k out equals bit k-1 in, and bit 0 out is 0.
- R5: The chain is 1 cell per input pin, 1 per output pin, 2 per tristate pin (o, oe) and 3 per bidirectional pin (i, o, oe, in that order). Pin 0 is nearest TDO. With the default pins (input, output, tristate, bidirectional) the chain is 7 cells, and chain bit k is the k-th bit shifted out or in.
- R6: Under SAMPLE/PRELOAD (code 3'b010) the pins stay in pass-through. The scan returns the values captured at Capture-DR (pad input for i cells, core output and core enable for o and oe cells). Update-DR loads the shifted data into the update latches.
- R7: Once EXTEST (code 3'b000) takes effect, pad outputs, pad enables and core inputs come from the update latches straight away, with no data scan needed.
- R8: Under EXTEST a data scan captures the current pin values. The driven values change only at Update-DR, not while shifting.
- R9: Reaching Test-Logic-Reset through TMS returns every pin to pass-through.
- R10: The user register (code 3'b011) is 3 bits. It captures its parallel input at Capture-DR and drives its parallel output from Update-DR. With the output looped back to the input, each scan returns the previous scan's data.
- R11: TDO changes only on the falling edge of TCK and is 0 outside Shift-IR and Shift-DR.
- R12: Signals with no cell are fixed. An input pin drives pad output and enable 0. An output pin drives pad enable 1 and core input 0. A tristate pin drives core input 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdo | output | 1 | Serial data out, falling-edge timed |
| pad_i | input | NPINS | Value seen at each pad |
| core_o | input | NPINS | Core output value per pin |
| core_oe | input | NPINS | Core output enable per pin |
| core_i | output | NPINS | Value delivered to the core per pin |
| pad_o | output | NPINS | Value driven to each pad |
| pad_oe | output | NPINS | Pad driver enable per pin |
| user_out | output | USER_LEN | Parallel output of the user register |
| user_in | input | USER_LEN | Parallel input captured by the user register |

## Verification
A wrong instruction or a wrong controller state appears at TDO in the very next scan: the capture pattern, the identifier or the one-bit bypass delay comes back wrong within a few TCK cycles. A wrong update latch or mode select appears on the pad and core-input pins as soon as the instruction or the data update takes effect. It is checked both before and after Update-DR, so a latch that updates too early is caught in the same scan. A fault in cell order or in the capture source shows up in the bit positions of the 7-bit chain readout.

// File: rtl/jtag_bscan_pkg.sv
package jtag_bscan_pkg;

   localparam int unsigned IR_W    = 3;
   localparam int unsigned MAX_PIN = 32;

   localparam logic [IR_W-1:0] INS_EXTEST = 3'b000;
   localparam logic [IR_W-1:0] INS_IDCODE = 3'b001;
   localparam logic [IR_W-1:0] INS_SAMPLE = 3'b010;
   localparam logic [IR_W-1:0] INS_USER   = 3'b011;
   localparam logic [IR_W-1:0] INS_BYPASS = 3'b111;

   typedef enum logic [3:0] {
      ST_RESET   = 4'd0,
      ST_IDLE    = 4'd1,
      ST_SEL_DR  = 4'd2,
      ST_CAP_DR  = 4'd3,
      ST_SH_DR   = 4'd4,
      ST_EX1_DR  = 4'd5,
      ST_PAU_DR  = 4'd6,
      ST_EX2_DR  = 4'd7,
      ST_UPD_DR  = 4'd8,
      ST_SEL_IR  = 4'd9,
      ST_CAP_IR  = 4'd10,
      ST_SH_IR   = 4'd11,
      ST_EX1_IR  = 4'd12,
      ST_PAU_IR  = 4'd13,
      ST_EX2_IR  = 4'd14,
      ST_UPD_IR  = 4'd15
   } tap_state_e;

   // pin kind codes, two bits per pin in the kinds vector
   localparam logic [1:0] PK_IN    = 2'd0;
   localparam logic [1:0] PK_OUT   = 2'd1;
   localparam logic [1:0] PK_TRI   = 2'd2;
   localparam logic [1:0] PK_BIDIR = 2'd3;

   function automatic int unsigned cell_count(input logic [1:0] kind);
      case (kind)
         PK_TRI:   return 2;
         PK_BIDIR: return 3;
         default:  return 1;
      endcase
   endfunction

   function automatic int unsigned cell_offset(input logic [2*MAX_PIN-1:0] kinds,
                                               input int unsigned pin);
      int unsigned sum;
      sum = 0;
      for (int unsigned i = 0; i < MAX_PIN; i++)
         if (i < pin) sum += cell_count(kinds[2*i +: 2]);
      return sum;
   endfunction

endpackage

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
   import jtag_bscan_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      case (state)
         ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
         ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         default:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= ST_RESET;
      else        state <= nxt;
   end

   // run length of TMS-high cycles, saturating at five
   logic [2:0] high_run;
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)             high_run <= 3'd0;
      else if (!tms)          high_run <= 3'd0;
      else if (high_run != 5) high_run <= high_run + 3'd1;
   end

   // R1
   tms_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (high_run == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/jtag_bscan_chain.sv
module jtag_bscan_chain
   import jtag_bscan_pkg::*;
#(
   parameter int unsigned           NPINS     = 4,
   parameter logic [2*NPINS-1:0]    PIN_KINDS = 8'hE4,
   parameter int unsigned           LEN       = 7
)(
   input  logic             tck,
   input  logic             rst_n,
   input  logic             tdi,
   input  logic             capture,
   input  logic             shift,
   input  logic             update,
   input  logic             extest,
   input  logic [NPINS-1:0] pad_i,
   input  logic [NPINS-1:0] core_o,
   input  logic [NPINS-1:0] core_oe,
   output logic [NPINS-1:0] core_i,
   output logic [NPINS-1:0] pad_o,
   output logic [NPINS-1:0] pad_oe,
   output logic             so
);

   localparam logic [2*MAX_PIN-1:0] KINDS_W = (2*MAX_PIN)'(PIN_KINDS);

   logic [LEN-1:0] cap_v;
   logic [LEN-1:0] sh_q;
   logic [LEN-1:0] upd_q;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      localparam int unsigned OFF  = cell_offset(KINDS_W, p);
      localparam logic [1:0]  KIND = PIN_KINDS[2*p +: 2];
      case (KIND)
         PK_IN: begin : g_in
            assign cap_v[OFF] = pad_i[p];
            assign core_i[p]  = extest ? upd_q[OFF] : pad_i[p];
            assign pad_o[p]   = 1'b0;
            assign pad_oe[p]  = 1'b0;
         end
         PK_OUT: begin : g_out
            assign cap_v[OFF] = core_o[p];
            assign pad_o[p]   = extest ? upd_q[OFF] : core_o[p];
            assign pad_oe[p]  = 1'b1;
            assign core_i[p]  = 1'b0;
         end
         PK_TRI: begin : g_tri
            assign cap_v[OFF]   = core_o[p];
            assign cap_v[OFF+1] = core_oe[p];
            assign pad_o[p]     = extest ? upd_q[OFF]   : core_o[p];
            assign pad_oe[p]    = extest ? upd_q[OFF+1] : core_oe[p];
            assign core_i[p]    = 1'b0;
         end
         default: begin : g_bidir
            assign cap_v[OFF]   = pad_i[p];
            assign cap_v[OFF+1] = core_o[p];
            assign cap_v[OFF+2] = core_oe[p];
            assign core_i[p]    = extest ? upd_q[OFF]   : pad_i[p];
            assign pad_o[p]     = extest ? upd_q[OFF+1] : core_o[p];
            assign pad_oe[p]    = extest ? upd_q[OFF+2] : core_oe[p];
         end
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (capture) sh_q <= cap_v;
      else if (shift)   sh_q <= {tdi, sh_q[LEN-1:1]};
   end

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)      upd_q <= '0;
      else if (update) upd_q <= sh_q;
   end

   assign so = sh_q[0];

   // R8
   latch_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
      !update |-> $stable(upd_q));

endmodule

// File: rtl/jtag_user_dr.sv
module jtag_user_dr #(
   parameter int unsigned LEN = 3
)(
   input  logic           tck,
   input  logic           rst_n,
   input  logic           tdi,
   input  logic           capture,
   input  logic           shift,
   input  logic           update,
   input  logic [LEN-1:0] par_i,
   output logic [LEN-1:0] par_o,
   output logic           so
);

   logic [LEN-1:0] sh_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (capture) sh_q <= par_i;
      else if (shift)   sh_q <= {tdi, sh_q[LEN-1:1]};
   end

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)      par_o <= '0;
      else if (update) par_o <= sh_q;
   end

   assign so = sh_q[0];

   // R10
   user_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
      !update |-> $stable(par_o));

endmodule

// File: rtl/jtag_bscan_tap.sv
module jtag_bscan_tap
   import jtag_bscan_pkg::*;
#(
   parameter int unsigned        NPINS     = 4,
   parameter logic [2*NPINS-1:0] PIN_KINDS = 8'hE4,
   parameter int unsigned        USER_LEN  = 3,
   parameter logic [31:0]        ID_CODE   = 32'h0A5C_3E6B
)(
   input  logic                tck,
   input  logic                tms,
   input  logic                tdi,
   input  logic                rst_n,
   output logic                tdo,
   input  logic [NPINS-1:0]    pad_i,
   input  logic [NPINS-1:0]    core_o,
   input  logic [NPINS-1:0]    core_oe,
   output logic [NPINS-1:0]    core_i,
   output logic [NPINS-1:0]    pad_o,
   output logic [NPINS-1:0]    pad_oe,
   output logic [USER_LEN-1:0] user_out,
   input  logic [USER_LEN-1:0] user_in
);

   localparam int unsigned CHAIN_LEN = cell_offset((2*MAX_PIN)'(PIN_KINDS), NPINS);

   initial begin
      assert (NPINS >= 1 && NPINS <= MAX_PIN) else $error("NPINS out of range");
      assert (ID_CODE[0] == 1'b1) else $error("ID_CODE LSB must be 1");
      assert (USER_LEN >= 2) else $error("USER_LEN must be at least 2");
      assert (CHAIN_LEN >= 2) else $error("chain must hold at least 2 cells");
   end

   tap_state_e state;

   jtag_tap_ctrl u_ctrl (
      .tck   (tck),
      .rst_n (rst_n),
      .tms   (tms),
      .state (state)
   );

   // instruction register
   logic [IR_W-1:0] ir_sh, ir_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                  ir_sh <= '0;
      else if (state == ST_CAP_IR) ir_sh <= 3'b001;
      else if (state == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
   end

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)                  ir_q <= INS_IDCODE;
      else if (state == ST_RESET)  ir_q <= INS_IDCODE;
      else if (state == ST_UPD_IR) ir_q <= ir_sh;
   end

   logic sel_ext, sel_chain, sel_id, sel_user, sel_byp;
   assign sel_ext   = (ir_q == INS_EXTEST);
   assign sel_chain = sel_ext || (ir_q == INS_SAMPLE);
   assign sel_id    = (ir_q == INS_IDCODE);
   assign sel_user  = (ir_q == INS_USER);
   assign sel_byp   = !(sel_chain || sel_id || sel_user);

   logic cap_dr, sh_dr, upd_dr;
   assign cap_dr = (state == ST_CAP_DR);
   assign sh_dr  = (state == ST_SH_DR);
   assign upd_dr = (state == ST_UPD_DR);

   // boundary chain
   logic chain_so;

   jtag_bscan_chain #(
      .NPINS     (NPINS),
      .PIN_KINDS (PIN_KINDS),
      .LEN       (CHAIN_LEN)
   ) u_chain (
      .tck     (tck),
      .rst_n   (rst_n),
      .tdi     (tdi),
      .capture (cap_dr && sel_chain),
      .shift   (sh_dr && sel_chain),
      .update  (upd_dr && sel_chain),
      .extest  (sel_ext),
      .pad_i   (pad_i),
      .core_o  (core_o),
      .core_oe (core_oe),
      .core_i  (core_i),
      .pad_o   (pad_o),
      .pad_oe  (pad_oe),
      .so      (chain_so)
   );

   // user register
   logic user_so;

   jtag_user_dr #(.LEN(USER_LEN)) u_user (
      .tck     (tck),
      .rst_n   (rst_n),
      .tdi     (tdi),
      .capture (cap_dr && sel_user),
      .shift   (sh_dr && sel_user),
      .update  (upd_dr && sel_user),
      .par_i   (user_in),
      .par_o   (user_out),
      .so      (user_so)
   );

   // identifier and bypass registers
   logic [31:0] id_q;
   logic        byp_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         id_q  <= '0;
         byp_q <= 1'b0;
      end else begin
         if (cap_dr && sel_id)      id_q <= ID_CODE;
         else if (sh_dr && sel_id)  id_q <= {tdi, id_q[31:1]};
         if (cap_dr && sel_byp)     byp_q <= 1'b0;
         else if (sh_dr && sel_byp) byp_q <= tdi;
      end
   end

   logic dr_so;
   always_comb begin
      if (sel_chain)     dr_so = chain_so;
      else if (sel_id)   dr_so = id_q[0];
      else if (sel_user) dr_so = user_so;
      else               dr_so = byp_q;
   end

   logic tdo_q;
   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)                 tdo_q <= 1'b0;
      else if (state == ST_SH_DR) tdo_q <= dr_so;
      else if (state == ST_SH_IR) tdo_q <= ir_sh[0];
      else                        tdo_q <= 1'b0;
   end
   assign tdo = tdo_q;

   // R3
   ir_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == ST_RESET) |-> (ir_q == INS_IDCODE));

   // R4
   bypass_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (sh_dr && sel_byp) |=> (byp_q == $past(tdi)));

   // R11
   tdo_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
      ($past(state) != ST_SH_DR && $past(state) != ST_SH_IR
       && state != ST_SH_DR && state != ST_SH_IR) |-> (tdo == 1'b0));

endmodule

// File: tb/jtag_bscan_tap_test.sv
`timescale 1ns/1ps
module jtag_bscan_tap_test;

   localparam logic [31:0] ID = 32'h0A5C_3E6B;

   logic       tck = 1'b0;
   logic       tms = 1'b1;
   logic       tdi = 1'b0;
   logic       rst_n = 1'b0;
   logic       tdo;
   logic [3:0] pad_i = '0, core_o = '0, core_oe = '0;
   logic [3:0] core_i, pad_o, pad_oe;
   logic [2:0] user_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 tck = ~tck;

   jtag_bscan_tap #(
      .NPINS(4), .PIN_KINDS(8'hE4), .USER_LEN(3), .ID_CODE(ID)
   ) uut (
      .tck(tck), .tms(tms), .tdi(tdi), .rst_n(rst_n), .tdo(tdo),
      .pad_i(pad_i), .core_o(core_o), .core_oe(core_oe),
      .core_i(core_i), .pad_o(pad_o), .pad_oe(pad_oe),
      .user_out(user_out), .user_in(user_out)
   );

   // entry: {instruction[2:0], length[5:0], data in[31:0], expected out[31:0]}
   localparam int NV = 6;
   localparam logic [72:0] VEC [NV] = '{
      {3'b111, 6'd8, 32'h0000_00B2, 32'h0000_0064},
      {3'b011, 6'd3, 32'h0000_0002, 32'h0000_0000},
      {3'b011, 6'd3, 32'h0000_0005, 32'h0000_0002},
      {3'b011, 6'd3, 32'h0000_0007, 32'h0000_0005},
      {3'b101, 6'd4, 32'h0000_000A, 32'h0000_0004},
      {3'b111, 6'd5, 32'h0000_001F, 32'h0000_001E}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one TCK cycle; entered and left 1 ns after a falling edge
   task automatic step(input logic m, input logic d, output logic pre, output logic post);
      pre = tdo;
      tms = m;
      tdi = d;
      @(posedge tck); #1;
      post = tdo;
      @(negedge tck); #1;
   endtask

   task automatic step0(input logic m);
      logic a, b;
      step(m, 1'b0, a, b);
   endtask

   task automatic load_ir(input logic [2:0] code, output logic [2:0] out);
      logic b, p;
      step0(1); step0(1); step0(0); step0(0);
      for (int k = 0; k < 3; k++) begin
         step(k == 2, code[k], b, p);
         out[k] = b;
      end
      step0(1); step0(0);
   endtask

   // leaves the controller in Exit1-DR
   task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
      logic b, p;
      dout = '0;
      step0(1); step0(0); step0(0);
      for (int k = 0; k < n; k++) begin
         step(k == n-1, din[k], b, p);
         dout[k] = b;
         // R11: TDO holds across the rising edge
         if (k == 0) chk("R11 tdo stable at rising edge", {31'b0, p}, {31'b0, b});
      end
   endtask

   task automatic update_dr();
      step0(1); step0(0);
   endtask

   // expected pins for input/output/tristate/bidir pins, from R5, R7 and R12
   task automatic chk_pins(input string req, input logic ext, input logic [6:0] lat);
      logic [3:0] ei, eo, ee;
      ei = {ext ? lat[4] : pad_i[3], 1'b0, 1'b0, ext ? lat[0] : pad_i[0]};
      eo = {ext ? lat[5] : core_o[3], ext ? lat[2] : core_o[2], ext ? lat[1] : core_o[1], 1'b0};
      ee = {ext ? lat[6] : core_oe[3], ext ? lat[3] : core_oe[2], 1'b1, 1'b0};
      chk({req, " core_i"}, {28'b0, core_i}, {28'b0, ei});
      chk({req, " pad_o"},  {28'b0, pad_o},  {28'b0, eo});
      chk({req, " pad_oe"}, {28'b0, pad_oe}, {28'b0, ee});
   endtask

   function automatic logic [6:0] cap_view();
      return {core_oe[3], core_o[3], pad_i[3], core_oe[2], core_o[2], core_o[1], pad_i[0]};
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL R1 watchdog expired actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [2:0]  irout;
      logic [31:0] dout;
      // reset state
      pad_i = 4'b1001; core_o = 4'b0110; core_oe = 4'b0100;
      repeat (3) @(negedge tck);
      #1;
      chk("R11 tdo in reset", {31'b0, tdo}, 32'h0);
      chk("R10 user_out in reset", {29'b0, user_out}, 32'h0);
      chk_pins("R12 reset pass-through", 1'b0, 7'h0);
      rst_n = 1'b1;
      @(negedge tck); #1;
      step0(0);

      // R3 identifier right after reset
      scan_dr(32, 32'h0, dout);
      update_dr();
      chk("R3 idcode after reset", dout, ID);
      chk("R3 idcode lsb", {31'b0, dout[0]}, 32'h1);

      // table walk: bypass, user register, unassigned code
      for (int v = 0; v < NV; v++) begin
         logic [2:0]  c;
         int          n;
         logic [31:0] din, exp, msk;
         c   = VEC[v][72:70];
         n   = int'(VEC[v][69:64]);
         din = VEC[v][63:32];
         exp = VEC[v][31:0];
         msk = (32'h1 << n) - 32'h1;
         load_ir(c, irout);
         chk("R2 ir capture pattern", {29'b0, irout}, 32'h1);
         scan_dr(n, din, dout);
         update_dr();
         if (c == 3'b011) begin
            chk("R10 user scan returns previous", dout & msk, exp);
            chk("R10 user_out after update", {29'b0, user_out}, din & msk);
         end else begin
            chk("R4 bypass one-bit delay", dout & msk, exp);
         end
      end

      // R6 sample/preload
      pad_i = 4'b0001; core_o = 4'b0100; core_oe = 4'b1100;
      load_ir(3'b010, irout);
      chk("R2 ir capture pattern", {29'b0, irout}, 32'h1);
      chk_pins("R6 sample pass-through", 1'b0, 7'h0);
      scan_dr(7, 32'h32, dout);
      chk("R5 R6 sampled chain", dout & 32'h7F, {25'b0, 7'b1001101});
      update_dr();
      chk_pins("R6 pass-through after preload", 1'b0, 7'h0);

      // R7 extest drives latches at once
      load_ir(3'b000, irout);
      chk_pins("R7 extest from preload", 1'b1, 7'h32);

      // R8 new scan under extest
      pad_i = 4'b1000; core_o = 4'b1010; core_oe = 4'b0000;
      scan_dr(7, 32'h4D, dout);
      chk("R8 extest capture", dout & 32'h7F, {25'b0, cap_view()});
      chk_pins("R8 unchanged before update", 1'b1, 7'h32);
      update_dr();
      chk_pins("R8 driven after update", 1'b1, 7'h4D);

      // R9 TMS reset
      pad_i = 4'b0001; core_o = 4'b1110; core_oe = 4'b1000;
      step0(1); step0(1); step0(1); step0(1); step0(1);
      chk_pins("R9 pass-through after tms reset", 1'b0, 7'h0);
      chk("R11 tdo quiet in reset", {31'b0, tdo}, 32'h0);
      step0(0);
      scan_dr(32, 32'hFFFF_FFFF, dout);
      update_dr();
      chk("R1 R3 idcode after tms reset", dout, ID);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule